// File: doc/BRIEF.md
# Chainable Byte-Framed SPI Slave

This block is the serial front end of a multi-channel output controller. A host writes command bytes over a four-wire SPI link and, in the same transfer, reads back a status byte. The block runs on a fast system clock. It brings chip select, serial clock and serial data in through two-flop synchronizers. It takes a data bit on each falling serial-clock edge and moves the output line on each rising edge, most significant bit first in both directions.

When chip select falls, the block loads the status byte into its 8-bit shift register. Before the first clock edge it drives a one-bit verdict on the previous frame: 1 if that frame was rejected, 0 if it was accepted. When chip select rises, the shift register is committed to the command output only if the number of falling clock edges counted was a whole, nonzero multiple of eight. Because the shift register feeds the output line, several devices can share one chip select, with each device's output wired to the next device's input. Each device keeps the last byte that reaches it.

The system clock must run at least four times faster than the serial clock, and the serial clock must be low whenever chip select changes.

Top module: `spi_chain_slave`

## Requirements
- R1: `spi_miso_oe_o` is 0 while chip select is high and becomes 1 after chip select goes low; it returns to 0 after chip select rises.
- R2: `spi_mosi_i` is sampled on each falling serial-clock edge and shifted in MSB first, so a committed `cmd_word_o` equals the last eight bits received, the earliest of them in bit 7.
- R3: When chip select falls, `diag_word_i` is captured. Rising edges 1 to 8 of the frame then put its bits 7 down to 0 on `spi_miso_o`, one bit per edge.
- R4: When chip select rises after 8, 16, 24 or any other nonzero multiple of eight falling edges, `cmd_word_o` takes the shift register value and `cmd_strobe_o` is high for exactly one system clock.
- R5: When chip select rises after any other count of falling edges, including zero, `cmd_word_o` keeps its value and `cmd_strobe_o` stays low.
- R6: After chip select falls and before the first rising edge, `spi_miso_o` shows the error flag: 1 if the previous frame was rejected, 0 if it was accepted. The flag is 0 after reset, and it is valid even when chip select was high for only one system clock.
- R7: Rising edge n, for n greater than 8, puts on `spi_miso_o` the bit that was sampled at falling edge n-8. This is the pass-through that lets devices share a chain.
- R8: After reset, `cmd_word_o` is 0, `cmd_strobe_o` is 0 and `spi_miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sclk_i | input | 1 | Serial clock, idles low |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| spi_miso_oe_o | output | 1 | Output enable for the serial data pad |
| diag_word_i | input | DATA_W | Status byte captured when chip select falls |
| cmd_word_o | output | DATA_W | Last committed command byte |
| cmd_strobe_o | output | 1 | One-cycle pulse when a command byte commits |

## Verification
Two events can fall in adjacent system cycles: the commit decision for one frame, which updates the error flag, and the loading of that flag onto the output for the next frame. The bench provokes this by closing some frames with chip select high for a single system clock, so the next chip-select fall reaches the synchronizer right after the rise. It then checks that the flag on the output already shows the verdict on the frame that just ended. The bench sweeps frame lengths from 0 to 24 clocks over several data and status patterns, and it predicts the commit outcome, the command byte and every output bit arithmetically.

// File: rtl/spi_chain_pkg.sv
// Package: shared constants and types of the chainable SPI slave.
// Assumes byte-framed transfers; the frame unit is fixed here.
package spi_chain_pkg;
    localparam int unsigned FRAME_BITS = 8;
    localparam int unsigned PIN_COUNT  = 3;
    typedef enum logic [1:0] {PIN_MOSI = 2'd0, PIN_SCLK = 2'd1, PIN_CSN = 2'd2} pin_idx_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous SPI pins.
// Each pin gets its own flop chain, all with equal latency, so that the
// relative timing between pins is preserved. Assumes STAGES >= 2.
module spi_pin_sync #(
    parameter int unsigned    WIDTH   = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES-1:0] stg;
        // Shift each pin through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {STAGES{RST_VAL[g]}};
            else        stg <= {stg[STAGES-2:0], pin_i[g]};
        end
        assign level_o[g] = stg[STAGES-1];
    end
endmodule

// File: rtl/spi_bit_counter.sv
// Module: counts serial-clock falling edges modulo DATA_W within a frame,
// and remembers whether at least one whole frame unit has been received.
// Assumes clear and advance are never high together.
module spi_bit_counter #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             unit_seen_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    // Step the modulo counter and latch the whole-unit flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_o       <= '0;
            unit_seen_o <= 1'b0;
        end else if (advance_i) begin
            if (cnt_o == LAST) begin
                cnt_o       <= '0;
                unit_seen_o <= 1'b1;
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_shift_path.sv
// Module: the serial shift register and the output-line register.
// The register is loaded in parallel at frame start. It shifts in on fall
// events and presents its MSB on rise events. The flag load puts a single
// bit on the line ahead of the first rise. Assumes load and shift are exclusive.
module spi_shift_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              drive_i,
    input  logic              flag_i,
    input  logic              flag_val_i,
    output logic [DATA_W-1:0] shreg_o,
    output logic              line_o
);
    // Parallel load at frame start, then shift in MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg_o <= '0;
        else if (load_i)  shreg_o <= load_val_i;
        else if (shift_i) shreg_o <= {shreg_o[DATA_W-2:0], bit_i};
    end

    // Output line register: the flag at frame start, then the MSB on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       line_o <= 1'b0;
        else if (flag_i)  line_o <= flag_val_i;
        else if (drive_i) line_o <= shreg_o[DATA_W-1];
    end
endmodule

// File: rtl/spi_chain_slave.sv
// Module: top of the chainable byte-framed SPI slave.
// It synchronizes the pins and detects their edges, then commits a frame on
// chip-select rise only after a whole nonzero number of DATA_W-bit units.
// It also keeps the transmission-error flag. Assumes clk >= 4x the serial clock
// and a serial clock that is low whenever chip select changes.
module spi_chain_slave #(
    parameter int unsigned DATA_W      = spi_chain_pkg::FRAME_BITS,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn_i,
    input  logic              spi_sclk_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    input  logic [DATA_W-1:0] diag_word_i,
    output logic [DATA_W-1:0] cmd_word_o,
    output logic              cmd_strobe_o
);
    import spi_chain_pkg::*;

    logic [PIN_COUNT-1:0] pins_raw, pins_sync;
    logic csn_s, sclk_s, mosi_s;
    logic csn_prev, sclk_prev;
    logic cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic              unit_seen;
    logic [DATA_W-1:0] shreg;
    logic              err_q;
    logic              commit_ok;

    assign pins_raw[PIN_CSN]  = spi_csn_i;
    assign pins_raw[PIN_SCLK] = spi_sclk_i;
    assign pins_raw[PIN_MOSI] = spi_mosi_i;

    spi_pin_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins_raw),
        .level_o(pins_sync)
    );

    assign csn_s  = pins_sync[PIN_CSN];
    assign sclk_s = pins_sync[PIN_SCLK];
    assign mosi_s = pins_sync[PIN_MOSI];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_prev  <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            csn_prev  <= csn_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall   = csn_prev & ~csn_s;
    assign cs_rise   = ~csn_prev & csn_s;
    assign sclk_rise = ~sclk_prev & sclk_s & ~csn_s;
    assign sclk_fall = sclk_prev & ~sclk_s & ~csn_s;

    spi_bit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (cs_fall),
        .advance_i  (sclk_fall),
        .cnt_o      (bit_cnt),
        .unit_seen_o(unit_seen)
    );

    spi_shift_path #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cs_fall),
        .load_val_i(diag_word_i),
        .shift_i   (sclk_fall),
        .bit_i     (mosi_s),
        .drive_i   (sclk_rise),
        .flag_i    (cs_fall),
        .flag_val_i(err_q),
        .shreg_o   (shreg),
        .line_o    (spi_miso_o)
    );

    assign commit_ok = cs_rise & unit_seen & (bit_cnt == '0);

    // Decide commit or reject at frame end and keep the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word_o   <= '0;
            cmd_strobe_o <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            cmd_strobe_o <= commit_ok;
            if (commit_ok) begin
                cmd_word_o <= shreg;
                err_q      <= 1'b0;
            end else if (cs_rise) begin
                err_q <= 1'b1;
            end
        end
    end

    assign spi_miso_oe_o = ~csn_s;
endmodule

// File: rtl/spi_chain_slave_sva.sv
// Module: property checker for spi_chain_slave, attached through bind.
// Observes ports and the internal edge events; drives nothing.
module spi_chain_slave_sva #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn_i,
    input logic              spi_miso_o,
    input logic              spi_miso_oe_o,
    input logic [DATA_W-1:0] cmd_word_o,
    input logic              cmd_strobe_o,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              cs_fall,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              err_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_csn_i, 3) && $past(spi_csn_i, 2)) |-> !spi_miso_oe_o);

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !cs_fall && bit_cnt != LAST) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

    assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !cs_fall) |=> $stable(spi_miso_o));

    assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o |=> !cmd_strobe_o);

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_word_o) |-> cmd_strobe_o);

    assert_flag_on_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (spi_miso_o == $past(err_q)));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o |-> !err_q);
endmodule

bind spi_chain_slave spi_chain_slave_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_csn_i    (spi_csn_i),
    .spi_miso_o   (spi_miso_o),
    .spi_miso_oe_o(spi_miso_oe_o),
    .cmd_word_o   (cmd_word_o),
    .cmd_strobe_o (cmd_strobe_o),
    .sclk_rise    (sclk_rise),
    .sclk_fall    (sclk_fall),
    .cs_fall      (cs_fall),
    .bit_cnt      (bit_cnt),
    .err_q        (err_q)
);

// File: tb/spi_chain_slave_tb.sv
// Bench: sweeps frame lengths 0..24 over several data and status patterns
// and predicts the commit result, error flag and every output bit.
module spi_chain_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe, strobe;
    logic [7:0] diag = 8'h00;
    logic [7:0] cmd;

    int checks = 0, fails = 0, strobe_cnt = 0, exp_strobes = 0;
    logic [7:0] exp_cmd = 8'h00;
    logic       err_model = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    spi_chain_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_csn_i(csn), .spi_sclk_i(sclk),
        .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
        .diag_word_i(diag), .cmd_word_o(cmd), .cmd_strobe_o(strobe)
    );

    always @(posedge clk) if (rst_n && strobe) strobe_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_commit();
        chk(cmd == exp_cmd, "R2 cmd_word", cmd, exp_cmd);
        chk(strobe_cnt == exp_strobes, "R4/R5 strobe count", strobe_cnt, exp_strobes);
    endtask

    task automatic frame(input int nbits, input logic [31:0] data, input logic [7:0] dw, input int cs_high);
        bit accept;
        diag = dw;
        csn  = 1'b0;
        wait_n(6);
        check_commit();
        chk(miso_oe == 1'b1, "R1 oe after cs low", miso_oe, 1);
        chk(miso == err_model, "R6 error flag", miso, err_model);
        for (int k = 0; k < nbits; k++) begin
            logic expb;
            mosi = data[nbits-1-k];
            wait_n(6);
            sclk = 1'b1;
            wait_n(6);
            if (k < 8) begin
                expb = dw[7-k];
                chk(miso == expb, "R3 status bit", miso, expb);
            end else begin
                expb = data[nbits-1-(k-8)];
                chk(miso == expb, "R7 pass-through bit", miso, expb);
            end
            sclk = 1'b0;
            wait_n(6);
        end
        csn = 1'b1;
        accept = (nbits > 0) && (nbits % 8 == 0);
        if (accept) begin
            exp_cmd = data[7:0];
            exp_strobes++;
        end
        err_model = !accept;
        wait_n(cs_high);
        if (cs_high >= 8) begin
            chk(miso_oe == 1'b0, "R1 oe after cs high", miso_oe, 0);
            check_commit();
        end
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk(cmd == 8'h00, "R8 reset cmd", cmd, 0);
        chk(strobe == 1'b0, "R8 reset strobe", strobe, 0);
        chk(miso_oe == 1'b0, "R8 reset oe", miso_oe, 0);
        for (int p = 0; p < 3; p++) begin
            for (int len = 0; len <= 24; len++) begin
                logic [31:0] pat;
                pat = (p == 0) ? 32'hA5C3_96E1 : (p == 1) ? (32'h1234_5678 ^ (len * 32'h0101_0101)) : 32'h0FF0_33CC;
                frame(len, pat, 8'(8'h3C ^ (len * 7) ^ (p * 8'h55)), (len % 5 == 0) ? 1 : 10);
            end
        end
        frame(8, 32'h0000_005A, 8'hC3, 10);
        chk(miso_oe == 1'b0, "R1 final oe", miso_oe, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule